// File: doc/BRIEF.md
# Strobed Parallel Register Port with Routing Table

This block sits on the peripheral side of a narrow parallel bus. A host drives eight input bits. Bit 7 acts as a strobe, and bits 6:0 carry a payload. Every transfer has two halves: the host presents the payload with the strobe low, then presents the same payload with the strobe high. The block takes the payload on the rising edge of the strobe. If payload bit 6 is set, bits 5:0 select one of 64 registers. If bit 6 is clear, bits 5:0 form a 6-bit value, which is written into the most recently selected register. The strobe reaches the block from another clock domain. It passes through a two-flop synchroniser, and its edge is detected in the block's own clock.

Four of the registers give access to a routing table. Each destination code in the table holds exactly one source code. To link a destination to a source, the host writes, in this order:
1. destination high part
2. destination low part
3. source high part
4. source low part

Writing the source low part commits the entry. Any source may feed any number of destinations. The block returns the contents of the selected register on an 8-bit read port that models the upper byte of the bus. A configuration input limits the read value to five valid bits.

Top module: `strobe_route_port`

## Requirements
- R1: After reset, `rd_data_o` is 0, the selected register is 0, every register holds 0, and every destination maps to source 0.
- R2: On a synchronised rising edge of `gpio_i[7]`, if payload bit 6 is 1, bits 5:0 become the selected register index.
- R3: On a rising edge, if payload bit 6 is 0, bits 5:0 are written into the selected register. The selection is kept, so later value phases write the same register again.
- R4: A payload change while the strobe stays high has no effect. A falling edge of the strobe has no effect.
- R5: With `narrow_rd_i` at 1, only bits 4:0 of the read value are shown and bits 7:5 are 0. With `narrow_rd_i` at 0, bits 5:0 are shown. `rd_data_o[7:6]` is always 0. A change of `narrow_rd_i` shows on the second falling clock edge after it is driven.
- R6: A strobe rising edge driven just after clock edge P0 updates the register state at P3 and `rd_data_o` at P4.
- R7: The register indices are:
  - 0x30: destination high; bits 2:0 form destination bits 7:5.
  - 0x31: destination low; bits 4:0 form destination bits 4:0.
  - 0x32: source high.
  - 0x33: source low.
- R8: A write to 0x33 sets the entry of the current destination to {bits 2:0 of register 0x32, written value bits 4:0}. A write to 0x32 alone leaves the table unchanged.
- R9: While 0x32 is selected, the read value is bits 7:5 of the current destination's source code. While 0x33 is selected, it is bits 4:0. A new destination changes the value read back.
- R10: One source code may be linked to several destinations at once. Writing a destination again replaces its previous source.
- R11: Every register other than 0x32 and 0x33 reads back the last 6-bit value written to it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gpio_i | input | 8 | Host bus: bit 7 is the strobe, bits 6:0 are the payload |
| narrow_rd_i | input | 1 | 1 limits the read value to five bits |
| rd_data_o | output | 8 | Read value of the selected register (upper bus byte) |

## Verification
A strobe rising edge driven just after clock edge P0 is seen in `rd_data_o` only after the fourth rising clock edge:
- two edges in the synchroniser,
- one edge to update the register, address or table state,
- one edge to register the read value.

A change of `narrow_rd_i` takes a single edge. The bench therefore holds a pending expected value together with a countdown. On each falling edge it decrements the countdown, makes the pending value the expected value when the count reaches zero, and only then compares the port. Each bus phase is held for seven cycles, so at most one update is pending at a time, and an early or late change is caught in the exact cycle where it differs.

// File: rtl/srp_pkg.sv
package srp_pkg;
  localparam int unsigned DST_HI_IDX = 'h30;
  localparam int unsigned DST_LO_IDX = 'h31;
  localparam int unsigned SRC_HI_IDX = 'h32;
  localparam int unsigned SRC_LO_IDX = 'h33;

  typedef enum logic [1:0] {
    RD_BANK   = 2'd0,
    RD_SRC_HI = 2'd1,
    RD_SRC_LO = 2'd2
  } rd_sel_e;
endpackage

// File: rtl/srp_sync.sv
module srp_sync #(
  parameter int unsigned BUS_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [BUS_W-1:0] bus_i,
  output logic [BUS_W-2:0] payload_o,
  output logic             rise_o
);
  logic [BUS_W-1:0] meta_q, sync_q;
  logic             strb_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q   <= '0;
      sync_q   <= '0;
      strb_d_q <= 1'b0;
    end else begin
      meta_q   <= bus_i;
      sync_q   <= meta_q;
      strb_d_q <= sync_q[BUS_W-1];
    end
  end

  // payload rides the same two stages so it lines up with the strobe edge
  assign rise_o    = sync_q[BUS_W-1] & ~strb_d_q;
  assign payload_o = sync_q[BUS_W-2:0];
endmodule

// File: rtl/srp_regs.sv
module srp_regs
  import srp_pkg::*;
#(
  parameter int unsigned VAL_W    = 6,
  parameter int unsigned DST_HI_W = 3,
  parameter int unsigned DST_LO_W = 5,
  parameter int unsigned SRC_HI_W = 3,
  parameter int unsigned SRC_LO_W = 5,
  localparam int unsigned PAY_W   = VAL_W + 1,
  localparam int unsigned NREG    = 2 ** VAL_W,
  localparam int unsigned DST_W   = DST_HI_W + DST_LO_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rise_i,
  input  logic [PAY_W-1:0]    payload_i,
  output logic [VAL_W-1:0]    addr_o,
  output logic [VAL_W-1:0]    bank_rd_o,
  output logic [DST_W-1:0]    dst_o,
  output logic [SRC_HI_W-1:0] src_hi_o,
  output logic                commit_o,
  output logic [SRC_LO_W-1:0] commit_lo_o
);
  logic [VAL_W-1:0] addr_q;
  logic [VAL_W-1:0] bank_q [NREG];
  logic             is_addr, wr_en;

  assign is_addr = payload_i[PAY_W-1];
  assign wr_en   = rise_i & ~is_addr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                addr_q <= '0;
    else if (rise_i && is_addr) addr_q <= payload_i[VAL_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) bank_q[i] <= '0;
    end else if (wr_en) begin
      bank_q[addr_q] <= payload_i[VAL_W-1:0];
    end
  end

  assign addr_o      = addr_q;
  assign bank_rd_o   = bank_q[addr_q];
  assign dst_o       = {bank_q[VAL_W'(DST_HI_IDX)][DST_HI_W-1:0],
                        bank_q[VAL_W'(DST_LO_IDX)][DST_LO_W-1:0]};
  assign src_hi_o    = bank_q[VAL_W'(SRC_HI_IDX)][SRC_HI_W-1:0];
  assign commit_o    = wr_en && (addr_q == VAL_W'(SRC_LO_IDX));
  assign commit_lo_o = payload_i[SRC_LO_W-1:0];
endmodule

// File: rtl/srp_route_tbl.sv
module srp_route_tbl #(
  parameter int unsigned DST_W = 8,
  parameter int unsigned SRC_W = 8,
  localparam int unsigned ENTRIES = 2 ** DST_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [DST_W-1:0] dst_i,
  input  logic [SRC_W-1:0] src_i,
  output logic [SRC_W-1:0] src_o
);
  logic [SRC_W-1:0] tbl_q [ENTRIES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) tbl_q[i] <= '0;
    end else if (we_i) begin
      tbl_q[dst_i] <= src_i;
    end
  end

  assign src_o = tbl_q[dst_i];
endmodule

// File: rtl/strobe_route_port.sv
module strobe_route_port
  import srp_pkg::*;
#(
  parameter int unsigned VAL_W    = 6,
  parameter int unsigned DST_HI_W = 3,
  parameter int unsigned DST_LO_W = 5,
  parameter int unsigned SRC_HI_W = 3,
  parameter int unsigned SRC_LO_W = 5,
  parameter int unsigned NARROW_W = 5,
  localparam int unsigned BUS_W   = VAL_W + 2,
  localparam int unsigned PAY_W   = VAL_W + 1,
  localparam int unsigned DST_W   = DST_HI_W + DST_LO_W,
  localparam int unsigned SRC_W   = SRC_HI_W + SRC_LO_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [BUS_W-1:0] gpio_i,
  input  logic             narrow_rd_i,
  output logic [BUS_W-1:0] rd_data_o
);
  logic                strobe_rise;
  logic [PAY_W-1:0]    payload;
  logic [VAL_W-1:0]    cur_addr, bank_rd;
  logic [DST_W-1:0]    dst_code;
  logic [SRC_HI_W-1:0] src_hi_stage;
  logic                tbl_we;
  logic [SRC_LO_W-1:0] commit_lo;
  logic [SRC_W-1:0]    route_src;
  rd_sel_e             rd_sel;
  logic [VAL_W-1:0]    rd_val, rd_masked, rd_q;

  srp_sync #(.BUS_W(BUS_W)) u_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bus_i     (gpio_i),
    .payload_o (payload),
    .rise_o    (strobe_rise)
  );

  srp_regs #(
    .VAL_W    (VAL_W),
    .DST_HI_W (DST_HI_W),
    .DST_LO_W (DST_LO_W),
    .SRC_HI_W (SRC_HI_W),
    .SRC_LO_W (SRC_LO_W)
  ) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rise_i      (strobe_rise),
    .payload_i   (payload),
    .addr_o      (cur_addr),
    .bank_rd_o   (bank_rd),
    .dst_o       (dst_code),
    .src_hi_o    (src_hi_stage),
    .commit_o    (tbl_we),
    .commit_lo_o (commit_lo)
  );

  srp_route_tbl #(.DST_W(DST_W), .SRC_W(SRC_W)) u_tbl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (tbl_we),
    .dst_i  (dst_code),
    .src_i  ({src_hi_stage, commit_lo}),
    .src_o  (route_src)
  );

  always_comb begin
    if (cur_addr == VAL_W'(SRC_HI_IDX))      rd_sel = RD_SRC_HI;
    else if (cur_addr == VAL_W'(SRC_LO_IDX)) rd_sel = RD_SRC_LO;
    else                                     rd_sel = RD_BANK;
  end

  always_comb begin
    unique case (rd_sel)
      RD_SRC_HI: rd_val = VAL_W'(route_src[SRC_W-1 -: SRC_HI_W]);
      RD_SRC_LO: rd_val = VAL_W'(route_src[SRC_LO_W-1:0]);
      default:   rd_val = bank_rd;
    endcase
  end

  assign rd_masked = narrow_rd_i ? VAL_W'(rd_val[NARROW_W-1:0]) : rd_val;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_q <= '0;
    else         rd_q <= rd_masked;
  end

  assign rd_data_o = {2'b00, rd_q};
endmodule

// File: rtl/srp_checker.sv
module srp_checker #(
  parameter int unsigned VAL_W    = 6,
  parameter int unsigned NARROW_W = 5,
  localparam int unsigned BUS_W   = VAL_W + 2,
  localparam int unsigned PAY_W   = VAL_W + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [BUS_W-1:0] gpio_i,
  input logic             narrow_rd_i,
  input logic [BUS_W-1:0] rd_data_o,
  input logic             rise_i,
  input logic [PAY_W-1:0] payload_i,
  input logic [VAL_W-1:0] addr_i,
  input logic             commit_i
);
  AST_TOP_BITS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[BUS_W-1:VAL_W] == '0); // R5

  AST_NARROW_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(narrow_rd_i) |-> rd_data_o[VAL_W-1:NARROW_W] == '0); // R5

  AST_ADDR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_i && payload_i[PAY_W-1] |=> addr_i == $past(payload_i[VAL_W-1:0])); // R2

  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rise_i |=> $stable(addr_i)); // R4

  AST_RISE_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_i |-> $past(gpio_i[BUS_W-1], 2)); // R6

  AST_COMMIT_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |-> rise_i && !payload_i[PAY_W-1]); // R8
endmodule

bind strobe_route_port srp_checker #(.VAL_W(VAL_W), .NARROW_W(NARROW_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .gpio_i      (gpio_i),
  .narrow_rd_i (narrow_rd_i),
  .rd_data_o   (rd_data_o),
  .rise_i      (strobe_rise),
  .payload_i   (payload),
  .addr_i      (cur_addr),
  .commit_i    (tbl_we)
);

// File: tb/tb_strobe_route_port.sv
module tb_strobe_route_port;
  logic       clk = 1'b0;
  logic       rst_ni;
  logic [7:0] gpio;
  logic       narrow;
  logic [7:0] rd;

  always #4 clk = ~clk;

  strobe_route_port dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .gpio_i      (gpio),
    .narrow_rd_i (narrow),
    .rd_data_o   (rd)
  );

  int    regs [64];
  int    tbl  [256];
  int    m_addr, m_narrow;
  int    exp_rd, pend_val, pend_cnt;
  int    n_chk, n_fail, cyc;
  bit    live, done;
  string cur_req;

  function automatic int dst_code();
    return ((regs['h30] & 7) << 5) | (regs['h31] & 31);
  endfunction

  function automatic int model_read();
    int v;
    if (m_addr == 'h32)      v = (tbl[dst_code()] >> 5) & 7;
    else if (m_addr == 'h33) v = tbl[dst_code()] & 31;
    else                     v = regs[m_addr];
    if (m_narrow != 0) v = v & 31;
    return v;
  endfunction

  task automatic sched(input int cnt);
    pend_val = model_read();
    pend_cnt = cnt;
  endtask

  task automatic drive(input logic [7:0] v);
    @(posedge clk);
    #1 gpio = v;
  endtask

  // low half, then high half; model takes effect on the high half
  task automatic phase(input int p);
    drive({1'b0, p[6:0]});
    repeat (6) @(posedge clk);
    drive({1'b1, p[6:0]});
    if (p[6]) m_addr = p & 63;
    else begin
      regs[m_addr] = p & 63;
      if (m_addr == 'h33) tbl[dst_code()] = ((regs['h32] & 7) << 5) | (p & 31);
    end
    sched(5);
    repeat (6) @(posedge clk);
  endtask

  task automatic sel(input int idx);
    phase(64 + idx);
  endtask

  task automatic put(input int v);
    phase(v & 63);
  endtask

  task automatic set_narrow(input int b);
    @(posedge clk);
    #1 narrow = b[0];
    m_narrow = b;
    sched(2);
    repeat (4) @(posedge clk);
  endtask

  task automatic link(input int dst, input int src);
    sel('h30); put(dst >> 5);
    sel('h31); put(dst & 31);
    sel('h32); put(src >> 5);
    sel('h33); put(src & 31);
  endtask

  task automatic summary();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(negedge clk) begin
    if (live && !done) begin
      if (pend_cnt > 0) begin
        pend_cnt--;
        if (pend_cnt == 0) exp_rd = pend_val;
      end
      n_chk++;
      if (rd !== exp_rd[7:0]) begin
        n_fail++;
        $display("FAIL %s: rd_data_o=%02h expected %02h (cycle %0d)", cur_req, rd, exp_rd[7:0], cyc);
      end
      cyc++;
      if (cyc > 100000) begin
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: cycles=%0d expected below 100000", cyc);
        summary();
      end
    end
  end

  initial begin
    foreach (regs[i]) regs[i] = 0;
    foreach (tbl[i]) tbl[i] = 0;
    m_addr = 0; m_narrow = 0; exp_rd = 0; pend_cnt = 0; pend_val = 0;
    n_chk = 0; n_fail = 0; cyc = 0; live = 0; done = 0;
    cur_req = "R1 reset";
    rst_ni = 1'b0; gpio = 8'h00; narrow = 1'b0;
    repeat (4) @(posedge clk);
    #1 rst_ni = 1'b1;
    live = 1'b1;
    repeat (4) @(posedge clk);

    cur_req = "R1 route reset";
    sel('h33);
    sel('h32);

    cur_req = "R2 R6 address select";
    sel('h05);
    cur_req = "R3 R11 value write";
    put('h2a);
    cur_req = "R3 repeated write";
    put('h15);
    put('h3c);
    cur_req = "R11 top register";
    sel('h3f); put('h3f);
    sel('h00); put('h01);
    sel('h05);

    cur_req = "R5 narrow read";
    set_narrow(1);
    sel('h3f);
    set_narrow(0);

    cur_req = "R4 change while high";
    sel('h07); put('h11);
    drive(8'hff);
    repeat (6) @(posedge clk);
    drive(8'ha2);
    repeat (6) @(posedge clk);
    drive(8'h00);
    repeat (8) @(posedge clk);

    cur_req = "R7 destination regs";
    sel('h30); put('h03);
    sel('h31); put('h11);
    cur_req = "R8 staged high only";
    sel('h32); put('h05);
    sel('h33);
    cur_req = "R8 commit on low";
    put('h1e);
    cur_req = "R9 source readback";
    sel('h32);
    sel('h33);

    cur_req = "R10 fan out";
    link('h05, 'hbe);
    sel('h32);
    cur_req = "R9 switch destination";
    sel('h30); put('h03);
    sel('h31); put('h11);
    sel('h33);
    sel('h32);
    cur_req = "R10 overwrite";
    link('h71, 'h43);
    sel('h33);
    sel('h31); put('h05);
    sel('h32);
    cur_req = "R5 narrow source";
    set_narrow(1);
    sel('h33);
    link('hff, 'hff);
    sel('h32);
    set_narrow(0);
    sel('h33);

    repeat (8) @(posedge clk);
    summary();
  end
endmodule